// File: doc/BRIEF.md
# SDRAM Initialization and Refresh Sequencer

This block owns the SDRAM command pins (chip select, row strobe, column strobe, write enable, clock enable, address and bank select). Leaving reset, it holds CKE high and sends only NOP until the power-up wait runs out. It then brings the memory up in a fixed order: a precharge of every bank, a programmable number of auto-refresh commands, and one mode register write. Once that write has settled, `ready_o` rises.

In service, an interval counter requests an auto-refresh at a fixed period. An outside access engine can borrow the command bus with a request/grant handshake. While the grant is held, its command, address and bank inputs reach the pins through one register stage. A refresh that falls due during a grant is held back until the grant is released. If the backlog grows past a second, longer window, a sticky overdue flag is set. The block then issues two refreshes back to back before it grants the bus again.

A level request puts the memory into self-refresh. Entry is an auto-refresh with CKE low in the same cycle. When the request drops, CKE rises and the block waits two cycles plus one row cycle before it allows any command. All timing is given as parameters in clock cycles.

Top module: `sdr_init_refresh_seq`

## Requirements
- R1: While reset is low and until the power-up wait of `T_PWRUP` cycles has passed, CKE is high, the pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), and `ready_o` and `bus_gnt_o` are low. The first command appears no earlier than `T_PWRUP` cycles after reset is released.
- R2: The power-up order is fixed. First comes a precharge (0010) with address bit 10 set. Then come exactly `INIT_REFS` auto-refreshes (0001). Then comes one mode register write (0000). `bus_gnt_o` stays low until that write has been issued, and `ready_o` rises no fewer than `T_MRD` cycles after it.
- R3: The mode register write carries bank 0. Its address holds the burst code in bits 2:0 (1→000, 2→001, 4→010, 8→011, any other value→111 full page), the wrap type in bit 3 (1 = interleaved), the CAS latency in bits 6:4, and zeros above.
- R4: Among commands the sequencer issues itself, the next command comes at least `T_RP` cycles after a precharge, at least `T_RC` cycles after an auto-refresh, and at least `T_MRD` cycles after a mode register write.
- R5: When idle with no request, consecutive auto-refreshes are exactly `T_REFI + 1` cycles apart.
- R6: In ready idle, `bus_req_i` raises `bus_gnt_o` the next cycle. While the grant is held, `usr_cmd_i`, `usr_addr_i` and `usr_ba_i` appear on the pins one cycle later. Dropping `bus_req_i` drops `bus_gnt_o` the next cycle.
- R7: No refresh is issued while the grant is held. If the grant is released after the refresh fell due but before `T_REFI + T_LATE` cycles have passed since the last refresh, exactly one refresh follows.
- R8: If the grant is held until `T_REFI + T_LATE` cycles have passed since the last refresh, two auto-refreshes exactly `T_RC` cycles apart follow its release.
- R9: From ready idle, `sr_req_i` causes an auto-refresh with CKE low in the same cycle. While the request stays high, CKE stays low, the pins carry NOP and `ready_o` is low.
- R10: When `sr_req_i` drops, CKE rises the next cycle. No command appears within `T_RC + 2` cycles of the CKE rise. `ready_o` returns exactly `T_RC + 2` cycles after the rise, and periodic refresh then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sr_req_i | input | 1 | Level request to stay in self-refresh |
| bus_req_i | input | 1 | Request to borrow the command bus |
| usr_cmd_i | input | 4 | Borrowed command {cs_n,ras_n,cas_n,we_n} |
| usr_addr_i | input | ADDR_W (12) | Borrowed address |
| usr_ba_i | input | BA_W (2) | Borrowed bank select |
| ready_o | output | 1 | Initialized and not in self-refresh |
| bus_gnt_o | output | 1 | Command bus granted to the access engine |
| cke_o | output | 1 | Clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W (12) | Address pins |
| ba_o | output | BA_W (2) | Bank select pins |

## Verification
The bench builds the block with a 40-cycle power-up wait, `T_RP` = 3, `T_RC` = 6, `T_MRD` = 2, a 60-cycle refresh interval and a 30-cycle lateness window. Power-up, several refresh periods, a deferred refresh, an overdue recovery pair and a full self-refresh round trip therefore all fit in a few hundred cycles. The mode settings are CAS latency 3, burst 8 and interleaved wrap, which gives address 0x03B and sets every non-zero field to a value distinct from its default. With these short values, a grant can be held past the due point alone or past the overdue window, so the bench reaches both release paths.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_MRS = 4'b0000;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_NOP = 4'b0111;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_INIT_REF,
    ST_MRS,
    ST_SETTLE,
    ST_IDLE,
    ST_REF,
    ST_GRANT,
    ST_SR
  } seq_state_e;
endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int W    = 8,
  parameter int INIT = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  localparam logic [W-1:0] RST_VAL = W'(INIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= RST_VAL;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdr_refresh_tracker.sv
module sdr_refresh_tracker #(
  parameter int T_REFI = 1560,
  parameter int T_LATE = 12480
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic ovd_clr_i,
  output logic due_o,
  output logic overdue_o
);
  localparam int CW = $clog2(T_REFI + T_LATE + 1);
  localparam logic [CW-1:0] DUE_AT = CW'(T_REFI);
  localparam logic [CW-1:0] LIMIT  = CW'(T_REFI + T_LATE);

  logic [CW-1:0] cnt_q;
  logic          ovd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (restart_i)             cnt_q <= '0;
    else if (run_i && cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
  end

  // sticky until the recovery pair starts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ovd_q <= 1'b0;
    else if (ovd_clr_i)      ovd_q <= 1'b0;
    else if (cnt_q == LIMIT) ovd_q <= 1'b1;
  end

  assign due_o     = (cnt_q >= DUE_AT);
  assign overdue_o = ovd_q;
endmodule

// File: rtl/sdr_mode_word.sv
module sdr_mode_word #(
  parameter int ADDR_W          = 12,
  parameter int CAS_LAT         = 2,
  parameter int BURST_LEN       = 4,
  parameter int WRAP_INTERLEAVE = 0
) (
  output logic [ADDR_W-1:0] word_o
);
  logic [2:0] bl_code;

  generate
    if (BURST_LEN == 1)      begin : g_bl1  assign bl_code = 3'd0; end
    else if (BURST_LEN == 2) begin : g_bl2  assign bl_code = 3'd1; end
    else if (BURST_LEN == 4) begin : g_bl4  assign bl_code = 3'd2; end
    else if (BURST_LEN == 8) begin : g_bl8  assign bl_code = 3'd3; end
    else                     begin : g_page assign bl_code = 3'd7; end
  endgenerate

  assign word_o = {{(ADDR_W-7){1'b0}}, 3'(CAS_LAT), 1'(WRAP_INTERLEAVE), bl_code};
endmodule

// File: rtl/sdr_init_refresh_seq.sv
module sdr_init_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int T_PWRUP         = 10000,
  parameter int T_RP            = 2,
  parameter int T_RC            = 8,
  parameter int T_MRD           = 2,
  parameter int T_REFI          = 1560,
  parameter int T_LATE          = 12480,
  parameter int INIT_REFS       = 8,
  parameter int CAS_LAT         = 2,
  parameter int BURST_LEN       = 4,
  parameter int WRAP_INTERLEAVE = 0,
  parameter int ADDR_W          = 12,
  parameter int BA_W            = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sr_req_i,
  input  logic              bus_req_i,
  input  logic [3:0]        usr_cmd_i,
  input  logic [ADDR_W-1:0] usr_addr_i,
  input  logic [BA_W-1:0]   usr_ba_i,
  output logic              ready_o,
  output logic              bus_gnt_o,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o
);
  localparam int T_XSR = T_RC + 2;
  localparam int M1    = (T_PWRUP > T_XSR) ? T_PWRUP : T_XSR;
  localparam int M2    = (T_RC > T_RP) ? T_RC : T_RP;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int WMAX  = (M3 > T_MRD) ? M3 : T_MRD;
  localparam int WW    = $clog2(WMAX + 1);
  localparam int RW    = $clog2(INIT_REFS + 1);

  localparam logic [WW-1:0] LD_RP  = WW'(T_RP - 1);
  localparam logic [WW-1:0] LD_RC  = WW'(T_RC - 1);
  localparam logic [WW-1:0] LD_MRD = WW'(T_MRD - 1);
  localparam logic [WW-1:0] LD_XSR = WW'(T_XSR - 1);
  localparam logic [RW-1:0] LAST_REF = RW'(INIT_REFS - 1);

  seq_state_e        state_q, state_d;
  logic [RW-1:0]     refs_q, refs_d;
  logic              rec_q, rec_d;
  logic [3:0]        cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BA_W-1:0]   ba_q, ba_d;
  logic              cke_q, cke_d;
  logic              load;
  logic [WW-1:0]     load_val;
  logic              go, ref_fire, ovd_clr, due, overdue;
  logic [ADDR_W-1:0] mode_word;

  sdr_gap_timer #(.W(WW), .INIT(T_PWRUP - 1)) i_gap_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (go)
  );

  sdr_refresh_tracker #(.T_REFI(T_REFI), .T_LATE(T_LATE)) i_ref_tracker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ready_o),
    .restart_i (ref_fire),
    .ovd_clr_i (ovd_clr),
    .due_o     (due),
    .overdue_o (overdue)
  );

  sdr_mode_word #(
    .ADDR_W(ADDR_W), .CAS_LAT(CAS_LAT),
    .BURST_LEN(BURST_LEN), .WRAP_INTERLEAVE(WRAP_INTERLEAVE)
  ) i_mode_word (
    .word_o (mode_word)
  );

  always_comb begin
    state_d  = state_q;
    refs_d   = refs_q;
    rec_d    = rec_q;
    cmd_d    = CMD_NOP;
    addr_d   = '0;
    ba_d     = '0;
    cke_d    = cke_q;
    load     = 1'b0;
    load_val = '0;
    ref_fire = 1'b0;
    ovd_clr  = 1'b0;
    unique case (state_q)
      ST_PWRUP: if (go) begin
        cmd_d      = CMD_PRE;
        addr_d[10] = 1'b1;
        load       = 1'b1;
        load_val   = LD_RP;
        refs_d     = '0;
        state_d    = ST_INIT_REF;
      end
      ST_INIT_REF: if (go) begin
        cmd_d    = CMD_REF;
        ref_fire = 1'b1;
        load     = 1'b1;
        load_val = LD_RC;
        refs_d   = refs_q + RW'(1);
        if (refs_q == LAST_REF) state_d = ST_MRS;
      end
      ST_MRS: if (go) begin
        cmd_d    = CMD_MRS;
        addr_d   = mode_word;
        load     = 1'b1;
        load_val = LD_MRD;
        state_d  = ST_SETTLE;
      end
      ST_SETTLE: if (go) state_d = ST_IDLE;
      ST_IDLE: begin
        if (overdue || due || sr_req_i) begin
          cmd_d    = CMD_REF;
          ref_fire = 1'b1;
          load     = 1'b1;
          load_val = LD_RC;
          state_d  = ST_REF;
          if (overdue) begin
            ovd_clr = 1'b1;
            rec_d   = 1'b1;
          end else if (!due) begin
            cke_d   = 1'b0;  // self-refresh entry
            state_d = ST_SR;
          end
        end else if (bus_req_i) begin
          state_d = ST_GRANT;
        end
      end
      ST_REF: if (go) begin
        if (rec_q) begin
          cmd_d    = CMD_REF;
          ref_fire = 1'b1;
          rec_d    = 1'b0;
          load     = 1'b1;
          load_val = LD_RC;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_GRANT: begin
        if (bus_req_i) begin
          cmd_d  = usr_cmd_i;
          addr_d = usr_addr_i;
          ba_d   = usr_ba_i;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_SR: if (!sr_req_i) begin
        cke_d    = 1'b1;
        load     = 1'b1;
        load_val = LD_XSR;
        state_d  = ST_SETTLE;
      end
      default: state_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWRUP;
      refs_q  <= '0;
      rec_q   <= 1'b0;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      ba_q    <= '0;
      cke_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      refs_q  <= refs_d;
      rec_q   <= rec_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      ba_q    <= ba_d;
      cke_q   <= cke_d;
    end
  end

  assign ready_o   = (state_q == ST_IDLE) || (state_q == ST_REF) || (state_q == ST_GRANT);
  assign bus_gnt_o = (state_q == ST_GRANT);
  assign cke_o     = cke_q;
  assign {cs_no, ras_no, cas_no, we_no} = cmd_q;
  assign addr_o    = addr_q;
  assign ba_o      = ba_q;
endmodule

// File: rtl/sdr_seq_chk.sv
module sdr_seq_chk #(
  parameter int T_RP  = 2,
  parameter int T_RC  = 8,
  parameter int T_MRD = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_req_i,
  input logic ready_o,
  input logic bus_gnt_o,
  input logic cke_o,
  input logic cs_no,
  input logic ras_no,
  input logic cas_no,
  input logic we_no
);
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [31:0] SAT  = 32'hFFFF_FFFF;

  logic [3:0]  cmd;
  logic        own_cmd;
  logic [31:0] gap_q, need_q, since_rise_q;
  logic        cke_prev_q, mrs_seen_q;

  assign cmd     = {cs_no, ras_no, cas_no, we_no};
  assign own_cmd = (cmd != C_NOP) && !bus_gnt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q        <= '0;
      need_q       <= '0;
      since_rise_q <= SAT;
      cke_prev_q   <= 1'b1;
      mrs_seen_q   <= 1'b0;
    end else begin
      cke_prev_q <= cke_o;
      if (own_cmd) begin
        gap_q  <= 32'd1;
        need_q <= (cmd == C_REF) ? 32'(T_RC) :
                  (cmd == C_PRE) ? 32'(T_RP) :
                  (cmd == C_MRS) ? 32'(T_MRD) : 32'd0;
      end else if (gap_q != SAT) begin
        gap_q <= gap_q + 32'd1;
      end
      if (cke_o && !cke_prev_q)   since_rise_q <= 32'd1;
      else if (since_rise_q != SAT) since_rise_q <= since_rise_q + 32'd1;
      if (own_cmd && cmd == C_MRS) mrs_seen_q <= 1'b1;
    end
  end

  a_r1_cke_high_in_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mrs_seen_q |-> cke_o);
  a_r2_no_ready_before_mrs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> mrs_seen_q);
  a_r4_cmd_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_cmd |-> gap_q >= need_q);
  a_r6_gnt_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_o |-> ready_o);
  a_r6_gnt_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_o |-> $past(bus_req_i));
  a_r9_entry_is_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> cmd == C_REF);
  a_r9_quiet_in_sr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && $past(!cke_o)) |-> (cmd == C_NOP && !ready_o));
  a_r10_exit_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_cmd |-> since_rise_q >= 32'(T_RC + 2));
endmodule

bind sdr_init_refresh_seq sdr_seq_chk #(
  .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)
) i_sdr_seq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_req_i (bus_req_i),
  .ready_o   (ready_o),
  .bus_gnt_o (bus_gnt_o),
  .cke_o     (cke_o),
  .cs_no     (cs_no),
  .ras_no    (ras_no),
  .cas_no    (cas_no),
  .we_no     (we_no)
);

// File: tb/test_sdr_init_refresh_seq.sv
`timescale 1ns/1ps
module test_sdr_init_refresh_seq;
  localparam int P_PWRUP = 40;
  localparam int P_RP    = 3;
  localparam int P_RC    = 6;
  localparam int P_MRD   = 2;
  localparam int P_REFI  = 60;
  localparam int P_LATE  = 30;
  localparam int P_REFS  = 8;
  localparam int AW      = 12;
  localparam int BW      = 2;
  localparam int WD_LIMIT = 20000;
  localparam logic [AW-1:0] MODE_EXP = 12'h03B; // CL3, interleaved, burst 8

  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_NOP = 4'b0111;

  logic clk = 1'b0, rst_n = 1'b0, sr_req = 1'b0, bus_req = 1'b0;
  logic [3:0]    usr_cmd  = C_NOP;
  logic [AW-1:0] usr_addr = '0;
  logic [BW-1:0] usr_ba   = '0;
  logic ready, gnt, cke, cs_n, ras_n, cas_n, we_n;
  logic [AW-1:0] addr;
  logic [BW-1:0] ba;
  logic [3:0]    pin_cmd;
  assign pin_cmd = {cs_n, ras_n, cas_n, we_n};

  sdr_init_refresh_seq #(
    .T_PWRUP(P_PWRUP), .T_RP(P_RP), .T_RC(P_RC), .T_MRD(P_MRD),
    .T_REFI(P_REFI), .T_LATE(P_LATE), .INIT_REFS(P_REFS),
    .CAS_LAT(3), .BURST_LEN(8), .WRAP_INTERLEAVE(1),
    .ADDR_W(AW), .BA_W(BW)
  ) i_sdr_init_refresh_seq (
    .clk_i(clk), .rst_ni(rst_n), .sr_req_i(sr_req), .bus_req_i(bus_req),
    .usr_cmd_i(usr_cmd), .usr_addr_i(usr_addr), .usr_ba_i(usr_ba),
    .ready_o(ready), .bus_gnt_o(gnt), .cke_o(cke),
    .cs_no(cs_n), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n),
    .addr_o(addr), .ba_o(ba)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vectors = 0, errs = 0;
  bit done = 1'b0;

  // monitor state
  int log_n = 0;
  logic [3:0]    log_cmd [16];
  logic [AW-1:0] log_addr[16];
  logic [BW-1:0] log_ba  [16];
  int            log_cyc [16];
  int last_cyc = -1000, last_need = 0, rise_cyc = -1000;
  int ref_n = 0, last_ref = 0, prev_ref = 0;
  bit mrs_seen = 1'b0, cke_prev = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (cke && !cke_prev) rise_cyc = cyc;
    cke_prev = cke;
    if (gnt && !mrs_seen) chk(1'b0, "R2", "grant before mode write", 1, 0);
    if (pin_cmd != C_NOP && !gnt) begin
      chk(cyc - last_cyc >= last_need, "R4", "command spacing", cyc - last_cyc, last_need);
      chk(cyc - rise_cyc >= P_RC + 2, "R10", "gap after CKE rise", cyc - rise_cyc, P_RC + 2);
      if (log_n < 16) begin
        log_cmd[log_n] = pin_cmd; log_addr[log_n] = addr;
        log_ba[log_n] = ba;       log_cyc[log_n] = cyc;
        log_n++;
      end
      last_cyc  = cyc;
      last_need = (pin_cmd == C_REF) ? P_RC : (pin_cmd == C_PRE) ? P_RP :
                  (pin_cmd == C_MRS) ? P_MRD : 0;
      if (pin_cmd == C_MRS) mrs_seen = 1'b1;
      if (pin_cmd == C_REF) begin
        ref_n++; prev_ref = last_ref; last_ref = cyc;
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_ref(input int base, input int cnt);
    for (int i = 0; i < 1000 && ref_n < base + cnt; i++) step();
  endtask

  int rel_cyc = 0;

  task automatic t_reset();
    repeat (3) step();
    chk(cke == 1'b1, "R1", "cke in reset", int'(cke), 1);
    chk(pin_cmd == C_NOP, "R1", "cmd in reset", int'(pin_cmd), int'(C_NOP));
    chk(!ready && !gnt, "R1", "ready/gnt in reset", int'({ready, gnt}), 0);
    rst_n = 1'b1;
    rel_cyc = cyc;
  endtask

  task automatic t_init();
    int rdy_cyc;
    bus_req = 1'b1;
    for (int i = 0; i < 400 && !ready; i++) step();
    rdy_cyc = cyc;
    chk(log_n >= P_REFS + 2, "R2", "init command count", log_n, P_REFS + 2);
    chk(log_cmd[0] == C_PRE && log_addr[0][10], "R2", "first is precharge all",
        int'(log_cmd[0]), int'(C_PRE));
    chk(log_cyc[0] - rel_cyc >= P_PWRUP, "R1", "power-up wait", log_cyc[0] - rel_cyc, P_PWRUP);
    for (int k = 1; k <= P_REFS; k++)
      chk(log_cmd[k] == C_REF, "R2", "init refresh", int'(log_cmd[k]), int'(C_REF));
    chk(log_cmd[P_REFS+1] == C_MRS, "R2", "mode write last", int'(log_cmd[P_REFS+1]), int'(C_MRS));
    chk(log_addr[P_REFS+1] == MODE_EXP, "R3", "mode address",
        int'(log_addr[P_REFS+1]), int'(MODE_EXP));
    chk(log_ba[P_REFS+1] == '0, "R3", "mode bank", int'(log_ba[P_REFS+1]), 0);
    chk(rdy_cyc - log_cyc[P_REFS+1] >= P_MRD, "R2", "ready after mode write",
        rdy_cyc - log_cyc[P_REFS+1], P_MRD);
    step();
    chk(gnt == 1'b1, "R6", "grant after ready", int'(gnt), 1);
  endtask

  task automatic t_grant_pass();
    usr_cmd = C_ACT; usr_addr = 12'h155; usr_ba = 2'd2;
    step();
    chk(pin_cmd == C_ACT, "R6", "user cmd on pins", int'(pin_cmd), int'(C_ACT));
    chk(addr == 12'h155 && ba == 2'd2, "R6", "user addr on pins", int'(addr), 'h155);
    usr_cmd = C_NOP; usr_addr = '0; usr_ba = '0;
    bus_req = 1'b0;
    step();
    chk(gnt == 1'b0, "R6", "grant released", int'(gnt), 0);
  endtask

  task automatic t_periodic();
    wait_ref(ref_n, 2);
    chk(last_ref - prev_ref == P_REFI + 1, "R5", "refresh interval", last_ref - prev_ref, P_REFI + 1);
  endtask

  task automatic t_defer();
    int base;
    wait_ref(ref_n, 1);
    base = ref_n;
    bus_req = 1'b1;
    for (int i = 0; i < 500 && cyc - last_ref < P_REFI + 10; i++) step();
    chk(ref_n == base, "R7", "no refresh during grant", ref_n - base, 0);
    bus_req = 1'b0;
    base = ref_n;
    repeat (3 * P_RC + 5) step();
    chk(ref_n == base + 1, "R7", "single deferred refresh", ref_n - base, 1);
  endtask

  task automatic t_overdue();
    int base;
    wait_ref(ref_n, 1);
    base = ref_n;
    bus_req = 1'b1;
    for (int i = 0; i < 500 && cyc - last_ref < P_REFI + P_LATE + 20; i++) step();
    chk(ref_n == base, "R7", "no refresh in long grant", ref_n - base, 0);
    bus_req = 1'b0;
    base = ref_n;
    repeat (2 * P_RC + 8) step();
    chk(ref_n == base + 2, "R8", "recovery refresh count", ref_n - base, 2);
    chk(last_ref - prev_ref == P_RC, "R8", "recovery spacing", last_ref - prev_ref, P_RC);
  endtask

  task automatic t_selfref();
    int base, rise, ok_cnt;
    wait_ref(ref_n, 1);
    repeat (10) step();
    sr_req = 1'b1;
    step();
    chk(cke == 1'b0 && pin_cmd == C_REF, "R9", "entry refresh with CKE low",
        int'({cke, pin_cmd}), int'({1'b0, C_REF}));
    chk(ready == 1'b0, "R9", "ready low in self-refresh", int'(ready), 0);
    ok_cnt = 0;
    base = ref_n;
    repeat (150) begin
      step();
      if (!cke && pin_cmd == C_NOP && !ready) ok_cnt++;
    end
    chk(ok_cnt == 150, "R9", "quiet cycles in self-refresh", ok_cnt, 150);
    chk(ref_n == base, "R9", "no refresh in self-refresh", ref_n - base, 0);
    sr_req = 1'b0;
    step();
    chk(cke == 1'b1, "R10", "CKE rises on exit", int'(cke), 1);
    rise = cyc;
    for (int i = 0; i < 100 && !ready; i++) step();
    chk(cyc - rise == P_RC + 2, "R10", "ready after exit", cyc - rise, P_RC + 2);
    base = ref_n;
    repeat (P_REFI + 10) step();
    chk(ref_n > base, "R10", "refresh resumes", ref_n - base, 1);
  endtask

  always @(posedge clk) if (!done && cyc == WD_LIMIT) begin
    errs++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WD_LIMIT);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    t_reset();
    t_init();
    t_grant_pass();
    t_periodic();
    t_defer();
    t_overdue();
    t_selfref();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule